// File: doc/BRIEF.md
# Programmable-Format Serial Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame. A producer offers a character with a valid/ready handshake. When the character is accepted, the block sends a low start bit and then the data bits, least significant first. An optional parity bit comes next, followed by a high stop period. A free-running tick at sixteen times the baud rate paces every bit. The baud divisor that produces this tick sits outside the block.

The frame format is taken from an 8-bit control byte when the character is accepted:

| Bits | Meaning |
|------|---------|
| [1:0] | Word length |
| [2] | Long stop period |
| [3] | Parity on/off |
| [4] | Parity sense |
| [5] | Forced parity |

The format can change from one frame to the next. A change made while a frame is on the line waits for the next frame. The control input is plain data, so a control byte of zero (5-bit words, one stop bit, no parity) is the format that results after reset when the driving register also clears.

The controller has five states:

| State | Line level |
|-------|------------|
| IDLE | high |
| START | low |
| DATA | current data bit |
| PARITY | parity bit |
| STOP | high |

The transitions are:

- IDLE→START when valid is seen while ready is high.
- START→DATA after one bit period.
- DATA→DATA after each bit period except the last data bit.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP after the last data bit when parity is off.
- PARITY→STOP after one bit period.
- STOP→IDLE when the stop period expires.

Reset forces IDLE from any state.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, the line is high, busy is 0 and ready is 1.
- R2: A character is accepted on a clock edge where valid and ready are both 1. From the next cycle the line carries a low start bit lasting 16 ticks, busy is 1 and ready is 0 until the frame has ended.
- R3: Control bits [1:0] select the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits go out least significant first, 16 ticks each. Data bits above the selected length are never sent.
- R4: The stop period is high. When control bit 2 is 0 it lasts 16 ticks. When bit 2 is 1 it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. Busy falls at the end of the stop period.
- R5: Control bit 3 = 1 inserts one parity bit of 16 ticks after the last data bit. Bit 3 = 0 sends no parity bit.
- R6: With parity on and control bit 5 = 0, bit 4 = 0 makes the total count of ones over the data and parity bits odd. Bit 4 = 1 makes that count even.
- R7: With parity on and control bit 5 = 1, the parity bit is fixed. It is 1 when bit 4 = 0 and 0 when bit 4 = 1.
- R8: The control byte is captured when the character is accepted. Changing it during a frame does not alter that frame.
- R9: Valid asserted while a frame is in progress is ignored. No extra frame follows.
- R10: Bit timing advances only on cycles where the baud tick is 1. Without ticks the line holds its current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the baud rate |
| fmt_ctrl | input | 8 | Frame format control byte |
| din | input | DATA_W | Character to send |
| din_valid | input | 1 | Character offered |
| din_ready | output | 1 | Block can accept a character |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default values: 8-bit data and 16 ticks per bit. With these values every word length from 5 to 8 is reachable, and so are all three stop-period lengths of 16, 24 and 32 ticks. In most runs the baud tick is held high every cycle, so each bit boundary falls on a known clock edge and the whole frame can be checked against exact cycle counts. One run withholds the tick for a while, which shows the frame stretching by exactly the number of missing ticks.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Field positions inside the control byte.
    localparam int CTL_WLEN_LO = 0;
    localparam int CTL_STOP    = 2;
    localparam int CTL_PAR_EN  = 3;
    localparam int CTL_PAR_SEL = 4;
    localparam int CTL_STICK   = 5;

    function automatic logic parity_of(input logic ones_xor, input logic sel, input logic stick);
        if (stick) begin
            return ~sel;
        end
        return sel ? ones_xor : ~ones_xor;
    endfunction

endpackage

// File: rtl/sft_fmt_decode.sv
module sft_fmt_decode
    import sft_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int IDX_W      = 4,
    parameter int CNT_W      = 6
) (
    input  logic [7:0]        ctrl,
    output logic [IDX_W-1:0]  n_bits,
    output logic [DATA_W-1:0] mask,
    output logic [CNT_W-1:0]  stop_len,
    output logic              par_en,
    output logic              par_sel,
    output logic              par_stick
);
    localparam int MIN_WORD = DATA_W - 3;
    localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVERSAMPLE);

    logic [1:0] wsel;

    always_comb begin
        wsel      = ctrl[CTL_WLEN_LO +: 2];
        n_bits    = IDX_W'(MIN_WORD) + IDX_W'(wsel);
        par_en    = ctrl[CTL_PAR_EN];
        par_sel   = ctrl[CTL_PAR_SEL];
        par_stick = ctrl[CTL_STICK];
        if (!ctrl[CTL_STOP]) begin
            stop_len = STOP_ONE;
        end else if (wsel == 2'b00) begin
            stop_len = STOP_HALF;
        end else begin
            stop_len = STOP_TWO;
        end
    end

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign mask[gi] = (IDX_W'(gi) < n_bits);
    end

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = tick && (cnt == limit - 1'b1);

endmodule

// File: rtl/sft_shift_parity.sv
module sft_shift_parity
    import sft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    input  logic              par_sel,
    input  logic              par_stick,
    output logic              ser_bit,
    output logic              par_bit
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] masked;

    assign masked = data & mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (load) begin
            shreg   <= masked;
            par_bit <= parity_of(^masked, par_sel, par_stick);
        end else if (shift) begin
            shreg   <= {1'b0, shreg[DATA_W-1:1]};
        end
    end

    assign ser_bit = shreg[0];

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [7:0]        fmt_ctrl,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              tx_line,
    output logic              tx_busy
);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
    localparam logic [CNT_W-1:0] BIT_LEN = CNT_W'(OVERSAMPLE);

    tx_state_e state, state_nx;

    logic [IDX_W-1:0]  dec_nbits;
    logic [DATA_W-1:0] dec_mask;
    logic [CNT_W-1:0]  dec_stop;
    logic              dec_par_en, dec_par_sel, dec_stick;

    logic [IDX_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  stop_q;
    logic              par_en_q;
    logic [IDX_W-1:0]  bit_idx;

    logic              accept, expire, restart;
    logic [CNT_W-1:0]  limit;
    logic              ser_bit, par_bit, shift_en;

    sft_fmt_decode #(
        .DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_dec (
        .ctrl      (fmt_ctrl),
        .n_bits    (dec_nbits),
        .mask      (dec_mask),
        .stop_len  (dec_stop),
        .par_en    (dec_par_en),
        .par_sel   (dec_par_sel),
        .par_stick (dec_stick)
    );

    sft_bit_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (baud_tick),
        .limit   (limit),
        .expire  (expire)
    );

    sft_shift_parity #(.DATA_W(DATA_W)) u_shp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .shift     (shift_en),
        .data      (din),
        .mask      (dec_mask),
        .par_sel   (dec_par_sel),
        .par_stick (dec_stick),
        .ser_bit   (ser_bit),
        .par_bit   (par_bit)
    );

    assign accept   = (state == ST_IDLE) && din_valid;
    assign restart  = (state == ST_IDLE) || expire;
    assign limit    = (state == ST_STOP) ? stop_q : BIT_LEN;
    assign shift_en = (state == ST_DATA) && expire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (din_valid) state_nx = ST_START;
            ST_START:  if (expire) state_nx = ST_DATA;
            ST_DATA: begin
                if (expire && (bit_idx == nbits_q - 1'b1)) begin
                    state_nx = par_en_q ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: if (expire) state_nx = ST_STOP;
            ST_STOP:   if (expire) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Frame format capture and data-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbits_q  <= '0;
            stop_q   <= BIT_LEN;
            par_en_q <= 1'b0;
            bit_idx  <= '0;
        end else begin
            if (accept) begin
                nbits_q  <= dec_nbits;
                stop_q   <= dec_stop;
                par_en_q <= dec_par_en;
            end
            if (state != ST_DATA) begin
                bit_idx <= '0;
            end else if (expire) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        tx_line   = 1'b1;
        tx_busy   = 1'b1;
        din_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tx_busy   = 1'b0;
                din_ready = 1'b1;
            end
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = ser_bit;
            ST_PARITY: tx_line = par_bit;
            ST_STOP:   tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
    end

endmodule

// File: rtl/sft_tx_checks.sv
module sft_tx_checks (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic din_valid,
    input logic din_ready,
    input logic tx_line,
    input logic tx_busy
);
    // R1: no frame in progress means the line is high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R2: acceptance leads to a start bit and busy
    assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din_ready) |=> (!tx_line && tx_busy));

    // R4: the frame ends after a high stop period
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> (tx_line && $past(tx_line)));

    // R9: no acceptance while a frame is in progress
    assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !din_ready);

    // R10: without a tick the line level holds
    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !baud_tick) |=> $stable(tx_line));
endmodule

bind serial_frame_tx sft_tx_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .tx_line   (tx_line),
    .tx_busy   (tx_busy)
);

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {ctrl, data, bits sent after start (LSB first), bit count, stop ticks}
    localparam logic [37:0] VEC [NVEC] = '{
        {8'h00, 8'hF5, 12'h015, 4'd5, 6'd16},
        {8'h04, 8'h0A, 12'h00A, 4'd5, 6'd24},
        {8'h0B, 8'hA5, 12'h1A5, 4'd9, 6'd16},
        {8'h1B, 8'hA5, 12'h0A5, 4'd9, 6'd16},
        {8'h1E, 8'h07, 12'h087, 4'd8, 6'd32},
        {8'h29, 8'h03, 12'h043, 4'd7, 6'd16},
        {8'h39, 8'h01, 12'h001, 4'd7, 6'd16},
        {8'h0D, 8'hFF, 12'h07F, 4'd7, 6'd32},
        {8'h08, 8'hE0, 12'h020, 4'd6, 6'd16},
        {8'h3C, 8'h1F, 12'h01F, 4'd6, 6'd24},
        {8'h03, 8'h5A, 12'h05A, 4'd8, 6'd16},
        {8'h07, 8'hC3, 12'h0C3, 4'd8, 6'd32}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic [7:0] fmt_ctrl = 8'h00;
    logic [7:0] din = 8'h00;
    logic din_valid = 1'b0;
    logic din_ready, tx_line, tx_busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_frame_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (tick_en),
        .fmt_ctrl  (fmt_ctrl),
        .din       (din),
        .din_valid (din_valid),
        .din_ready (din_ready),
        .tx_line   (tx_line),
        .tx_busy   (tx_busy)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input logic [11:0] eb,
                             input int nb, input int st, input int hold, input bit disturb);
        int len;
        int j;
        logic [11:0] got;
        bit start_ok, stop_ok, busy_ok;
        len = 16 * (1 + nb) + st;
        got = '0;
        start_ok = 1'b1;
        stop_ok = 1'b1;
        busy_ok = 1'b1;
        @(negedge clk);
        fmt_ctrl = c;
        din = d;
        din_valid = 1'b1;
        tick_en = (hold == 0);
        @(posedge clk);
        for (int i = 0; i <= len + hold; i++) begin
            @(negedge clk);
            if (i == 0) din_valid = 1'b0;
            if (i == hold) tick_en = 1'b1;
            if (disturb && i == 20) fmt_ctrl = 8'hFF;
            if (disturb && i == 30) begin din = 8'h00; din_valid = 1'b1; end
            if (disturb && i == 31) din_valid = 1'b0;
            j = i - hold;
            if (i < hold && tx_line !== 1'b0) start_ok = 1'b0;
            if (j == 8 && tx_line !== 1'b0) start_ok = 1'b0;
            if (j >= 16 && j < 16 * (1 + nb) && (j % 16) == 8) got[j / 16 - 1] = tx_line;
            if (j >= 16 * (1 + nb) && tx_line !== 1'b1) stop_ok = 1'b0;
            if (j < len && (tx_busy !== 1'b1 || din_ready !== 1'b0)) busy_ok = 1'b0;
            if (j == len && (tx_busy !== 1'b0 || din_ready !== 1'b1)) busy_ok = 1'b0;
        end
        chk(start_ok, $sformatf("R2 start bit ctrl=%h", c), start_ok, 1);
        chk(got == eb, $sformatf("R3 R5 R6 R7 frame bits ctrl=%h", c), got, eb);
        chk(stop_ok, $sformatf("R4 stop level ctrl=%h", c), stop_ok, 1);
        chk(busy_ok, $sformatf("R4 frame length %0d ctrl=%h", len + hold, c), busy_ok, 1);
        if (disturb) begin
            stop_ok = 1'b1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (tx_line !== 1'b1 || tx_busy !== 1'b0) stop_ok = 1'b0;
            end
            chk(stop_ok, "R9 no frame from valid seen while busy", stop_ok, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_line === 1'b1 && tx_busy === 1'b0 && din_ready === 1'b1, "R1 in reset",
            {tx_line, tx_busy, din_ready}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1 && tx_busy === 1'b0 && din_ready === 1'b1, "R1 after reset",
            {tx_line, tx_busy, din_ready}, 3'b101);

        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][37:30], VEC[v][29:22], VEC[v][21:10],
                      int'(VEC[v][9:6]), int'(VEC[v][5:0]), 0, 1'b0);
        end

        // R8 and R9: control change and valid during a 5-bit frame
        run_frame(8'h00, 8'h13, 12'h013, 5, 16, 0, 1'b1);
        // R10: ticks withheld for 50 cycles stretch the start bit
        run_frame(8'h0B, 8'h3C, 12'h13C, 9, 16, 50, 1'b0);

        // R1: reset during a frame returns to idle
        @(negedge clk);
        fmt_ctrl = 8'h03;
        din = 8'h00;
        din_valid = 1'b1;
        @(negedge clk);
        din_valid = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_line === 1'b1 && tx_busy === 1'b0 && din_ready === 1'b1, "R1 reset mid-frame",
            {tx_line, tx_busy, din_ready}, 3'b101);
        rst_n = 1'b1;
        run_frame(8'h00, 8'h1F, 12'h01F, 5, 16, 0, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule